// File: doc/BRIEF.md
# Partitioned 8x16 Fixed-Point Multiplier

This block multiplies small pixel fields by signed 16-bit coefficients across a 64-bit operand pair in one pass. The first source supplies 8-bit multiplicands, either unsigned bytes or signed upper halves of 16-bit words. The second source supplies the signed 16-bit multipliers. A 3-bit opcode picks how the multiplicands and multipliers pair up.

Every lane product is widened to 32 bits and rounded with a single rule. Five of the modes return four 16-bit results, taken from the middle of each rounded product. The two wide modes return two unscaled 32-bit products. One register stage holds the result. A valid strobe travels alongside the data, and an unused opcode gives a zero result with a flag.

Lanes count from the least significant end. Word lane r is bits 16r+15:16r of an operand and byte lane r is bits 8r+7:8r.

Top module: `pmul_unit`

## Requirements
- R1: While rst_ni is low, valid_o, illegal_o and result_o are all 0.
- R2: valid_o equals valid_i one clock earlier. result_o and illegal_o are updated only on a clock where valid_i is 1. When valid_i is 0, result_o holds its value and illegal_o goes to 0.
- R3: Each lane forms a 32-bit two's-complement product. If bit 7 of that product is 1 (low byte above 0x7F), 0x100 is added before any slicing. Narrow modes return bits 23:8 of the rounded product.
- R4: Opcode 0 (per-lane): result word r is the rounded product of unsigned byte r of src1_i and signed word r of src2_i, for r = 0..3.
- R5: Opcode 1 multiplies each unsigned byte r of src1_i by signed word 0 of src2_i. Opcode 2 does the same with signed word 1 of src2_i.
- R6: Opcode 3 (signed-upper): the multiplicand for lane r is bits 16r+15:16r+8 of src1_i, read as a signed byte. It is multiplied by signed word r of src2_i. The low byte of each src1_i word has no effect.
- R7: Opcode 4 (unsigned-lower): the multiplicand for lane r is bits 16r+7:16r of src1_i, read as unsigned. It is multiplied by signed word r of src2_i. The high byte of each src1_i word has no effect.
- R8: Opcodes 5 and 6 use the operand choice of opcodes 3 and 4 respectively, but only for lanes 0 and 1. Each places its full rounded 32-bit product, unshifted, into bits 32r+31:32r of result_o. Words 2 and 3 of both sources have no effect.
- R9: Opcode 7 gives result_o = 0 and illegal_o = 1 on the output cycle. illegal_o is 1 only together with valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands and opcode are valid this cycle |
| op_i | input | 3 | Mode select, encodings 0..6 legal, 7 illegal |
| src1_i | input | 64 | Multiplicand source (bytes or word upper/lower bytes) |
| src2_i | input | 64 | Signed 16-bit multiplier source |
| valid_o | output | 1 | result_o holds a new result |
| result_o | output | 64 | Packed 16-bit or 32-bit lane results |
| illegal_o | output | 1 | Last accepted opcode was unused |

## Verification
On every cycle, the assertions check the valid pipeline, that the result holds on idle cycles, and how the illegal flag relates to a zero result. They also check that each wide-mode half is a sign-extended value of at most 24 significant bits. Only the bench's scenarios can show that the numbers are right. That covers rounding on both sides of 0x7F, per-mode operand selection, which source bits are ignored, and the extremes 0x80, 0xFF and 0x8000. The bench checks these against hand-computed vectors and against an independent model fed random and corner operands.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [2:0] {
    OP_LANE  = 3'd0,
    OP_BC_LO = 3'd1,
    OP_BC_HI = 3'd2,
    OP_SUP   = 3'd3,
    OP_ULO   = 3'd4,
    OP_WSUP  = 3'd5,
    OP_WULO  = 3'd6,
    OP_BAD   = 3'd7
  } pmul_op_e;

  function automatic logic op_is_wide(input logic [2:0] op);
    return (op == OP_WSUP) || (op == OP_WULO);
  endfunction

  function automatic logic op_is_bad(input logic [2:0] op);
    return op == OP_BAD;
  endfunction
endpackage

// File: rtl/pmul_opsel.sv
module pmul_opsel
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  localparam int DATA_W = LANES * WORD_W
) (
  input  logic [2:0]                    op_i,
  input  logic [DATA_W-1:0]             src1_i,
  input  logic [DATA_W-1:0]             src2_i,
  output logic [LANES-1:0][BYTE_W:0]    mcand_o,
  output logic [LANES-1:0][WORD_W-1:0]  mplier_o
);
  logic [WORD_W-1:0] w0, w1;
  assign w0 = src2_i[0 +: WORD_W];
  assign w1 = src2_i[WORD_W +: WORD_W];

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    logic [BYTE_W-1:0] pix, hi, lo;
    logic [WORD_W-1:0] own;
    assign pix = src1_i[r*BYTE_W +: BYTE_W];
    assign hi  = src1_i[r*WORD_W+BYTE_W +: BYTE_W];
    assign lo  = src1_i[r*WORD_W +: BYTE_W];
    assign own = src2_i[r*WORD_W +: WORD_W];

    always_comb begin
      mcand_o[r]  = '0;
      mplier_o[r] = '0;
      unique case (pmul_op_e'(op_i))
        OP_LANE:          begin mcand_o[r] = {1'b0, pix};          mplier_o[r] = own; end
        OP_BC_LO:         begin mcand_o[r] = {1'b0, pix};          mplier_o[r] = w0;  end
        OP_BC_HI:         begin mcand_o[r] = {1'b0, pix};          mplier_o[r] = w1;  end
        OP_SUP, OP_WSUP:  begin mcand_o[r] = {hi[BYTE_W-1], hi};   mplier_o[r] = own; end
        OP_ULO, OP_WULO:  begin mcand_o[r] = {1'b0, lo};           mplier_o[r] = own; end
        default:          ;
      endcase
    end
  end
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  localparam int RAW_W  = BYTE_W + 1 + WORD_W,
  localparam int PROD_W = 2 * WORD_W
) (
  input  logic [BYTE_W:0]   mcand_i,
  input  logic [WORD_W-1:0] mplier_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [RAW_W-1:0]  raw;
  logic        [PROD_W-1:0] ext;

  assign raw = $signed(mcand_i) * $signed(mplier_i);
  assign ext = {{(PROD_W-RAW_W){raw[RAW_W-1]}}, raw};
  // round half-up on the discarded low byte, applied before any slicing
  assign prod_o = ext + (ext[BYTE_W-1] ? PROD_W'(1) << BYTE_W : '0);
endmodule

// File: rtl/pmul_pack.sv
module pmul_pack #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  localparam int PROD_W = 2 * WORD_W,
  localparam int DATA_W = LANES * WORD_W
) (
  input  logic                          wide_i,
  input  logic                          bad_i,
  input  logic [LANES-1:0][PROD_W-1:0]  prod_i,
  output logic [DATA_W-1:0]             result_o
);
  always_comb begin
    result_o = '0;
    for (int r = 0; r < LANES; r++) begin
      logic [PROD_W-1:0] part;
      part = wide_i ? prod_i[r]
                    : {{(PROD_W-WORD_W){1'b0}}, prod_i[r][BYTE_W +: WORD_W]};
      // wide lanes past the word boundary shift out of range and vanish
      result_o = result_o
               | (DATA_W'(part) << (r * (wide_i ? PROD_W : WORD_W)));
    end
    if (bad_i) result_o = '0;
  end
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  localparam int PROD_W = 2 * WORD_W,
  localparam int DATA_W = LANES * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  logic [LANES-1:0][BYTE_W:0]   mcand;
  logic [LANES-1:0][WORD_W-1:0] mplier;
  logic [LANES-1:0][PROD_W-1:0] prod;
  logic [DATA_W-1:0]            res_d;
  logic                         bad;

  assign bad = op_is_bad(op_i);

  pmul_opsel #(.LANES(LANES), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_opsel (
    .op_i     (op_i),
    .src1_i   (src1_i),
    .src2_i   (src2_i),
    .mcand_o  (mcand),
    .mplier_o (mplier)
  );

  for (genvar r = 0; r < LANES; r++) begin : g_mul
    pmul_lane #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_lane (
      .mcand_i  (mcand[r]),
      .mplier_i (mplier[r]),
      .prod_o   (prod[r])
    );
  end

  pmul_pack #(.LANES(LANES), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
    .wide_i   (op_is_wide(op_i)),
    .bad_i    (bad),
    .prod_i   (prod),
    .result_o (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i && bad;
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);
  assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && !illegal_o);
  assert_bad_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd7) |=> illegal_o && result_o == '0);
  assert_flag_with_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> valid_o);
  assert_wide_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd5 || op_i == 3'd6)) |=>
      (result_o[31:23] == 9'h000 || result_o[31:23] == 9'h1FF) &&
      (result_o[63:55] == 9'h000 || result_o[63:55] == 9'h1FF));
endmodule

bind pmul_unit pmul_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/pmul_unit_bench.sv
`timescale 1ns/100ps
module pmul_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] src1_i = '0;
  logic [63:0] src2_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  pmul_unit u_pmul_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src1_i(src1_i), .src2_i(src2_i), .valid_o(valid_o),
    .result_o(result_o), .illegal_o(illegal_o)
  );

  localparam int NV = 10;
  localparam logic [2:0] T_OP [NV] = '{3'd0, 3'd0, 3'd0, 3'd1, 3'd2,
                                       3'd3, 3'd4, 3'd5, 3'd6, 3'd0};
  localparam logic [63:0] T_S1 [NV] = '{
    64'h0000_0000_0000_0002, 64'h0000_0000_0000_0101, 64'h0000_0000_0000_00FF,
    64'h0000_0000_0403_0201, 64'h0000_0000_0403_0201, 64'h0000_0000_0200_FF7F,
    64'h0000_0000_01FF_7F80, 64'hAAAA_BBBB_FE00_0300, 64'h5555_6666_33FF_0110,
    64'h0000_0000_8000_0000};
  localparam logic [63:0] T_S2 [NV] = '{
    64'h0000_0000_0000_0100, 64'h0000_0000_007F_0080, 64'h0000_0000_0000_8000,
    64'h0000_0000_0200_0100, 64'h0000_0000_0200_0100, 64'h0000_0000_0300_0100,
    64'h0000_0000_FFFF_0100, 64'h1234_5678_0001_0040, 64'h9ABC_DEF0_7FFF_0010,
    64'h8000_0000_0000_0000};
  localparam logic [63:0] T_EXP [NV] = '{
    64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_8080,
    64'h0004_0003_0002_0001, 64'h0008_0006_0004_0002, 64'h0000_0000_0006_FFFF,
    64'h0000_0000_FFFF_0080, 64'h0000_00FE_0000_01C0, 64'h007F_7F01_0000_0100,
    64'hC000_0000_0000_0000};
  localparam string T_REQ [NV] = '{"R4", "R3", "R3", "R5", "R5",
                                   "R6", "R7", "R8", "R8", "R4"};

  // independent model of the requirements
  function automatic logic [63:0] model(input logic [2:0] op,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] out = '0;
    if (op == 3'd7) return '0;
    for (int r = 0; r < 4; r++) begin
      longint m, k, p;
      logic [31:0] t;
      if (op >= 3'd5 && r > 1) continue;
      case (op)
        3'd0, 3'd1, 3'd2: m = longint'(a[8*r +: 8]);
        3'd3, 3'd5:       m = longint'($signed(a[16*r+8 +: 8]));
        default:          m = longint'(a[16*r +: 8]);
      endcase
      case (op)
        3'd1:    k = longint'($signed(b[15:0]));
        3'd2:    k = longint'($signed(b[31:16]));
        default: k = longint'($signed(b[16*r +: 16]));
      endcase
      p = m * k;
      t = p[31:0];
      if (t[7:0] > 8'h7F) t = t + 32'h100;
      if (op >= 3'd5) out[32*r +: 32] = t;
      else            out[16*r +: 16] = t[23:8];
    end
    return out;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk_i);
    op_i = op; src1_i = a; src2_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 valid", 64'(valid_o), 64'd0);
    chk("R1 illegal", 64'(illegal_o), 64'd0);
    chk("R1 result", result_o, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(T_OP[i], T_S1[i], T_S2[i]);
      chk(T_REQ[i], result_o, T_EXP[i]);
      chk("R2 valid", 64'(valid_o), 64'd1);
      chk("R9 flag low", 64'(illegal_o), 64'd0);
    end

    // R9: unused opcode
    issue(3'd7, '1, '1);
    chk("R9 zero", result_o, 64'd0);
    chk("R9 flag", 64'(illegal_o), 64'd1);

    // R2: idle cycles hold result, drop valid and flag
    issue(3'd0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0100);
    @(negedge clk_i);
    op_i = 3'd7; src1_i = '1; src2_i = '1;
    @(negedge clk_i);
    chk("R2 hold", result_o, 64'h3);
    chk("R2 valid low", 64'(valid_o), 64'd0);
    chk("R2 flag low", 64'(illegal_o), 64'd0);

    // R6/R7/R8: ignored bytes and words have no effect
    issue(3'd3, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0100);
    chk("R6 low byte ignored", result_o, 64'h0000_0000_0000_FFFF);
    issue(3'd4, 64'h0000_0000_0000_FF80, 64'h0000_0000_0000_0100);
    chk("R7 high byte ignored", result_o, 64'h0000_0000_0000_0080);
    issue(3'd6, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000);
    chk("R8 upper words ignored", result_o, 64'd0);

    // random and corner operands against the model, all opcodes
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      logic [2:0] op;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      op = 3'($urandom_range(0, 7));
      if (i % 4 == 1) a = 64'h8080_8080_8080_8080;
      if (i % 4 == 2) b = 64'h8000_8000_8000_8000;
      if (i % 8 == 3) begin a = '1; b = 64'h8000_7FFF_8000_7FFF; end
      issue(op, a, b);
      chk(op >= 3'd5 ? "R8 model" : op == 3'd7 ? "R9 model" : "R4 R5 R6 R7 model",
          result_o, model(op, a, b));
      chk("R9 flag model", 64'(illegal_o), 64'(op == 3'd7));
    end

    // R1: reset mid-stream clears outputs
    issue(3'd0, 64'hFF, 64'h7FFF);
    rst_ni = 1'b0;
    #1;
    chk("R1 async result", result_o, 64'd0);
    chk("R1 async valid", 64'(valid_o), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule